// File: doc/BRIEF.md
# Serial GPIO Bitstream Controller

This block extends a chip's general-purpose pin count through a chain of external shift registers. It serialises up to 32 ports, each of 1 to 4 bits, onto a three-wire serial link: a serial clock, a data-out line and a load strobe. On the same slots it shifts the returning data-in line back into capture registers. Each port has a configuration word in which every output bit owns a 3-bit source field. Only the lowest bit of each field, the static level, is honoured here. Ports that are not enabled are left out of the chain completely.

Software programs the port words, the enable mask, the bits-per-port count, the clock divider and the run mode through a simple register bus. Writes are taken on the clock edge. Reads are combinational from the address. A frame visits the enabled ports in ascending order and, within each port, the bits in ascending order. One load slot closes the frame. Captured inputs are collected in a shadow store and published at the end of the frame as one word per bit index, in which the bit position is the port number. Frames can run back to back in auto-repeat mode, or one at a time from a self-clearing start bit.

Top module: `sgpio_stream_ctrl`

## Requirements
- R1: After reset all registers read zero, including the port words, mask, control, divider and the four input words, and ser_clk, ser_dout and ser_load are low. No frame runs until one is requested.
- R2: A frame visits the enabled ports, with port p enabled when mask bit p (address 0x20) is 1, from port 0 upward. Within each port the bits go from bit 0 upward. Disabled ports get no slot, so a frame has exactly popcount(mask) times bits-per-port data slots.
- R3: During the slot for port p, bit b, ser_dout equals bit 3*b of the port word at address p. The other two bits of that 3-bit field have no effect on the output.
- R4: Control bits [1:0] (address 0x21) hold the bits-per-port count minus one, giving 1 to 4 bits per port.
- R5: The divider D is the low 12 bits at address 0x22. Each slot lasts D system clocks, with ser_clk low for the first floor(D/2) clocks and high for the rest. A value below 2 acts as 2.
- R6: After the last data slot, ser_load is high for exactly one slot (D clocks). While it is high, ser_clk and ser_dout are low.
- R7: ser_din is sampled in the last system clock of each data slot. After the load slot ends, bit N of the input word at address 0x24+B holds the sample for port N, bit B. Positions the frame did not visit read 0. The input words change only at the end of a load slot.
- R8: With control bit 2 (auto-repeat) set, a new frame begins on the clock right after the load slot ends. The first ser_clk rise of that frame comes floor(D/2) clocks later. After auto-repeat is cleared, the running frame completes and then the link goes idle.
- R9: With auto-repeat clear, writing 1 to control bit 3 starts one frame. Bit 3 reads 1 until that frame's load slot ends, then reads 0, and no further frame follows.
- R10: A frame with an all-zero mask consists of the load slot only.
- R11: The mask, bits-per-port and divider are captured at frame start. Writing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| ser_clk | output | 1 | Serial shift clock |
| ser_dout | output | 1 | Serial output data |
| ser_load | output | 1 | Load strobe, one slot per frame |
| ser_din | input | 1 | Serial input data |

## Verification
A write takes effect at the clock edge that samples it. A start request moves the sequencer out of idle one edge after that. Every serial output is a decode of registered state, so it is valid from the edge that sets it. The bench therefore observes everything at falling edges. It counts falling edges within each frame and uses that count to check slot widths, the ser_clk high time, the load width and the floor(D/2) delay from one frame's end to the next frame's first rise. The bench drives ser_din right after each ser_clk rise, so the value is stable at the slot's final edge where it is sampled. Input words are read only after ser_load falls, which is the edge that publishes them.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2
  } sgp_state_e;

  localparam int unsigned SGP_MIN_DIV = 2;

endpackage

// File: rtl/sgp_port_pick.sv
module sgp_port_pick #(
  parameter int NUM_PORTS = 32,
  parameter int PIDX_W    = 5
) (
  input  logic [NUM_PORTS-1:0] mask,
  input  logic [PIDX_W:0]      from_idx,
  output logic                 found,
  output logic [PIDX_W-1:0]    idx
);

  // lowest enabled port at or above from_idx
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from_idx))) begin
        found = 1'b1;
        idx   = PIDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/sgp_slot_timer.sv
module sgp_slot_timer #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_act,
  output logic             slot_end,
  output logic             phase_hi
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last     = (cnt_q == (div_act - DIV_W'(1)));
  assign slot_end = run && last;
  assign phase_hi = (cnt_q >= (div_act >> 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: the slot counter never passes the latched divider
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div_act));

endmodule

// File: rtl/sgp_regs.sv
module sgp_regs #(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  parameter int SRC_W     = 3,
  parameter int DIV_W     = 12,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic                           start_done,
  input  logic                           pub_en,
  input  logic [MAX_BITS*NUM_PORTS-1:0]  pub_data,
  output logic [NUM_PORTS*MAX_BITS*SRC_W-1:0] cfg_flat,
  output logic [NUM_PORTS-1:0]           en_mask,
  output logic [((MAX_BITS>1)?$clog2(MAX_BITS):1)-1:0] bpp_m1,
  output logic                           auto_rep,
  output logic                           start_pend,
  output logic [DIV_W-1:0]               div_val
);

  localparam int CFG_W     = MAX_BITS * SRC_W;
  localparam int BPP_W     = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam int AUTO_BIT  = BPP_W;
  localparam int START_BIT = BPP_W + 1;
  localparam int A_MASK    = NUM_PORTS;
  localparam int A_CTRL    = NUM_PORTS + 1;
  localparam int A_DIV     = NUM_PORTS + 2;
  localparam int A_IN0     = NUM_PORTS + 4;
  localparam int IN_FLAT_W = MAX_BITS * NUM_PORTS;

  logic [CFG_W-1:0]     cfg_q [NUM_PORTS];
  logic [CFG_W-1:0]     cfg_d [NUM_PORTS];
  logic [NUM_PORTS-1:0] inw_q [MAX_BITS];
  logic [NUM_PORTS-1:0] inw_d [MAX_BITS];
  logic [NUM_PORTS-1:0] mask_q, mask_d;
  logic [BPP_W-1:0]     bpp_q, bpp_d;
  logic                 auto_q, auto_d;
  logic                 pend_q, pend_d;
  logic [DIV_W-1:0]     div_q, div_d;
  logic [IN_FLAT_W-1:0] inw_flat;
  logic                 wr_ctrl;

  assign wr_ctrl = bus_wr && (int'(bus_addr) == A_CTRL);

  // next-state for all programmable and captured state
  always_comb begin
    cfg_d  = cfg_q;
    inw_d  = inw_q;
    mask_d = mask_q;
    bpp_d  = bpp_q;
    auto_d = auto_q;
    div_d  = div_q;
    pend_d = pend_q;
    if (start_done) pend_d = 1'b0;
    if (bus_wr) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (int'(bus_addr) == p) cfg_d[p] = bus_wdata[CFG_W-1:0];
      end
      if (int'(bus_addr) == A_MASK) mask_d = bus_wdata[NUM_PORTS-1:0];
      if (int'(bus_addr) == A_DIV)  div_d  = bus_wdata[DIV_W-1:0];
    end
    if (wr_ctrl) begin
      bpp_d  = bus_wdata[BPP_W-1:0];
      auto_d = bus_wdata[AUTO_BIT];
      if (bus_wdata[START_BIT]) pend_d = 1'b1;
    end
    if (pub_en) begin
      for (int b = 0; b < MAX_BITS; b++) begin
        inw_d[b] = pub_data[b*NUM_PORTS +: NUM_PORTS];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PORTS; p++) cfg_q[p] <= '0;
      for (int b = 0; b < MAX_BITS; b++)  inw_q[b] <= '0;
      mask_q <= '0;
      bpp_q  <= '0;
      auto_q <= 1'b0;
      pend_q <= 1'b0;
      div_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      inw_q  <= inw_d;
      mask_q <= mask_d;
      bpp_q  <= bpp_d;
      auto_q <= auto_d;
      pend_q <= pend_d;
      div_q  <= div_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(bus_addr) == p) bus_rdata[CFG_W-1:0] = cfg_q[p];
    end
    if (int'(bus_addr) == A_MASK) bus_rdata[NUM_PORTS-1:0] = mask_q;
    if (int'(bus_addr) == A_CTRL) begin
      bus_rdata[BPP_W-1:0]  = bpp_q;
      bus_rdata[AUTO_BIT]   = auto_q;
      bus_rdata[START_BIT]  = pend_q;
    end
    if (int'(bus_addr) == A_DIV) bus_rdata[DIV_W-1:0] = div_q;
    for (int b = 0; b < MAX_BITS; b++) begin
      if (int'(bus_addr) == A_IN0 + b) bus_rdata[NUM_PORTS-1:0] = inw_q[b];
    end
  end

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_cfg
    assign cfg_flat[gp*CFG_W +: CFG_W] = cfg_q[gp];
  end
  for (genvar gb = 0; gb < MAX_BITS; gb++) begin : g_inw
    assign inw_flat[gb*NUM_PORTS +: NUM_PORTS] = inw_q[gb];
  end

  assign en_mask    = mask_q;
  assign bpp_m1     = bpp_q;
  assign auto_rep   = auto_q;
  assign start_pend = pend_q;
  assign div_val    = div_q;

  // R7: readable input words move only when a frame publishes
  a_r7_publish_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inw_flat) |-> $past(pub_en));

  // R9: a start write is always seen as pending on the next cycle
  a_r9_start_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[START_BIT]) |=> start_pend);

endmodule

// File: rtl/sgp_seq.sv
module sgp_seq
  import sgp_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  parameter int SRC_W     = 3,
  parameter int DIV_W     = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_PORTS*MAX_BITS*SRC_W-1:0]  cfg_flat,
  input  logic [NUM_PORTS-1:0]                 en_mask,
  input  logic [((MAX_BITS>1)?$clog2(MAX_BITS):1)-1:0] bpp_m1,
  input  logic                                 auto_rep,
  input  logic                                 start_pend,
  input  logic [DIV_W-1:0]                     div_val,
  input  logic                                 ser_din,
  output logic                                 ser_clk,
  output logic                                 ser_dout,
  output logic                                 ser_load,
  output logic                                 start_done,
  output logic                                 pub_en,
  output logic [MAX_BITS*NUM_PORTS-1:0]        pub_data
);

  localparam int CFG_W  = MAX_BITS * SRC_W;
  localparam int BPP_W  = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int SH_W   = MAX_BITS * NUM_PORTS;

  sgp_state_e           state_q, state_d;
  logic [PIDX_W-1:0]    port_q, port_d;
  logic [BPP_W-1:0]     bit_q, bit_d;
  logic [NUM_PORTS-1:0] mask_q, mask_d;
  logic [BPP_W-1:0]     bpp_q, bpp_d;
  logic [DIV_W-1:0]     div_q, div_d;
  logic [SH_W-1:0]      shadow_q, shadow_d;

  logic                 slot_end, phase_hi, run;
  logic                 begin_frame, go;
  logic [NUM_PORTS-1:0] pick_mask;
  logic [PIDX_W:0]      pick_from;
  logic                 pick_found;
  logic [PIDX_W-1:0]    pick_idx;
  logic [DIV_W-1:0]     div_eff;

  assign run         = (state_q != ST_IDLE);
  assign go          = auto_rep || start_pend;
  assign begin_frame = ((state_q == ST_IDLE) && go) ||
                       ((state_q == ST_LOAD) && slot_end && auto_rep);
  assign pick_mask   = begin_frame ? en_mask : mask_q;
  assign pick_from   = begin_frame ? '0 : ({1'b0, port_q} + (PIDX_W+1)'(1));
  assign div_eff     = (div_val < DIV_W'(SGP_MIN_DIV)) ? DIV_W'(SGP_MIN_DIV) : div_val;

  sgp_slot_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .div_act  (div_q),
    .slot_end (slot_end),
    .phase_hi (phase_hi)
  );

  sgp_port_pick #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_pick (
    .mask     (pick_mask),
    .from_idx (pick_from),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  always_comb begin
    state_d  = state_q;
    port_d   = port_q;
    bit_d    = bit_q;
    mask_d   = mask_q;
    bpp_d    = bpp_q;
    div_d    = div_q;
    shadow_d = shadow_q;
    if (begin_frame) begin
      mask_d   = en_mask;
      bpp_d    = bpp_m1;
      div_d    = div_eff;
      shadow_d = '0;
      bit_d    = '0;
      if (pick_found) begin
        state_d = ST_SHIFT;
        port_d  = pick_idx;
      end else begin
        state_d = ST_LOAD;
        port_d  = '0;
      end
    end else begin
      unique case (state_q)
        ST_SHIFT: begin
          if (slot_end) begin
            shadow_d[int'(bit_q)*NUM_PORTS + int'(port_q)] = ser_din;
            if (bit_q != bpp_q) begin
              bit_d = bit_q + BPP_W'(1);
            end else if (pick_found) begin
              port_d = pick_idx;
              bit_d  = '0;
            end else begin
              state_d = ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (slot_end) state_d = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      port_q   <= '0;
      bit_q    <= '0;
      mask_q   <= '0;
      bpp_q    <= '0;
      div_q    <= '0;
      shadow_q <= '0;
    end else begin
      state_q  <= state_d;
      port_q   <= port_d;
      bit_q    <= bit_d;
      mask_q   <= mask_d;
      bpp_q    <= bpp_d;
      div_q    <= div_d;
      shadow_q <= shadow_d;
    end
  end

  assign ser_clk    = (state_q == ST_SHIFT) && phase_hi;
  assign ser_load   = (state_q == ST_LOAD);
  assign ser_dout   = (state_q == ST_SHIFT) &&
                      cfg_flat[int'(port_q)*CFG_W + int'(bit_q)*SRC_W];
  assign start_done = (state_q == ST_LOAD) && slot_end;
  assign pub_en     = start_done;
  assign pub_data   = shadow_q;

  // R6: the load slot keeps clock and data quiet
  a_r6_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> (!ser_clk && !ser_dout));

  // R2: only enabled ports occupy data slots
  a_r2_port_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> mask_q[port_q]);

  // R4: bit index stays within the latched bits-per-port
  a_r4_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (bit_q <= bpp_q));

  // R8: auto-repeat leaves no idle cycle between frames
  a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_LOAD) && slot_end && auto_rep) |=> (state_q != ST_IDLE));

  // R9: a pending start clears only as a load slot finishes
  a_r9_clear_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_pend) |-> $past(start_done));

endmodule

// File: rtl/sgpio_stream_ctrl.sv
module sgpio_stream_ctrl #(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  parameter int SRC_W     = 3,
  parameter int DIV_W     = 12,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ser_clk,
  output logic              ser_dout,
  output logic              ser_load,
  input  logic              ser_din
);

  localparam int CFG_W = MAX_BITS * SRC_W;
  localparam int BPP_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam int SH_W  = MAX_BITS * NUM_PORTS;

  logic                       rst_meta_n, rst_sync_n;
  logic [NUM_PORTS*CFG_W-1:0] cfg_flat;
  logic [NUM_PORTS-1:0]       en_mask;
  logic [BPP_W-1:0]           bpp_m1;
  logic                       auto_rep, start_pend, start_done, pub_en;
  logic [DIV_W-1:0]           div_val;
  logic [SH_W-1:0]            pub_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  sgp_regs #(
    .NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS), .SRC_W(SRC_W),
    .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .start_done (start_done),
    .pub_en     (pub_en),
    .pub_data   (pub_data),
    .cfg_flat   (cfg_flat),
    .en_mask    (en_mask),
    .bpp_m1     (bpp_m1),
    .auto_rep   (auto_rep),
    .start_pend (start_pend),
    .div_val    (div_val)
  );

  sgp_seq #(
    .NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS), .SRC_W(SRC_W), .DIV_W(DIV_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_flat   (cfg_flat),
    .en_mask    (en_mask),
    .bpp_m1     (bpp_m1),
    .auto_rep   (auto_rep),
    .start_pend (start_pend),
    .div_val    (div_val),
    .ser_din    (ser_din),
    .ser_clk    (ser_clk),
    .ser_dout   (ser_dout),
    .ser_load   (ser_load),
    .start_done (start_done),
    .pub_en     (pub_en),
    .pub_data   (pub_data)
  );

endmodule

// File: tb/sgpio_stream_ctrl_tb_top.sv
module sgpio_stream_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ser_clk, ser_dout, ser_load, ser_din;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam int A_MASK = 32, A_CTRL = 33, A_DIV = 34, A_IN0 = 36;

  sgpio_stream_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_clk(ser_clk),
    .ser_dout(ser_dout), .ser_load(ser_load), .ser_din(ser_din)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] cfgv(input int p);
    return 12'((p * 12'h9E3) ^ 12'h5B6);
  endfunction

  function automatic bit fsd(input int p, input int b, input int seed);
    return ((p * 5 + b * 3 + seed) % 7) < 3;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 6'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic setup(input logic [31:0] m, input int nb, input int dv, input bit au, input bit st);
    wr(A_DIV, 32'(dv));
    wr(A_MASK, m);
    wr(A_CTRL, 32'((nb - 1) | (int'(au) << 2) | (int'(st) << 3)));
  endtask

  // act: 0 none, 1 clear mask mid-frame, 2 turn auto-repeat off at start
  task automatic watch_frame(input logic [31:0] m, input int nb, input int dv,
                             input int seed, input bit gap_chk, input int act,
                             input bit single);
    int sp[128];
    int sb[128];
    int n = 0;
    logic [31:0] expw[4];
    logic [31:0] rv;
    int j = 0, hi_len = 0, load_len = 0, k = 0, first_rise = -1;
    bit prev_clk = 0, seen_load = 0, done = 0;
    for (int p = 0; p < 32; p++)
      if (m[p]) for (int b = 0; b < nb; b++) begin sp[n] = p; sb[n] = b; n++; end
    for (int b = 0; b < 4; b++) expw[b] = '0;
    while (!done && k < 20000) begin
      @(negedge clk);
      if (act == 1 && k == 10) begin bus_wr = 1; bus_addr = 6'(A_MASK); bus_wdata = '0; end
      if (act == 2 && k == 0) begin bus_wr = 1; bus_addr = 6'(A_CTRL); bus_wdata = 32'(nb - 1); end
      if (k == 11 || (act == 2 && k == 1)) bus_wr = 0;
      if (single && k == 0) begin
        rd(A_CTRL, rv);
        chk(rv[3] == 1'b1, "R9 start pending", rv[3], 1);
      end
      if (ser_clk && !prev_clk) begin
        if (first_rise < 0) first_rise = k;
        if (j < n) begin
          chk(ser_dout == cfgv(sp[j])[3*sb[j]], "R2/R3 dout order/level", ser_dout, cfgv(sp[j])[3*sb[j]]);
          ser_din = fsd(sp[j], sb[j], seed);
          if (ser_din) expw[sb[j]][sp[j]] = 1'b1;
        end
        j++;
        hi_len = 0;
      end
      if (!ser_clk && prev_clk) chk(hi_len == dv - dv / 2, "R5 clk high time", hi_len, dv - dv / 2);
      if (ser_clk) hi_len++;
      if (ser_load) begin
        load_len++;
        seen_load = 1;
        if (ser_clk || ser_dout) chk(0, "R6 quiet load", {ser_clk, ser_dout}, 0);
      end
      if (seen_load && !ser_load) done = 1;
      prev_clk = ser_clk;
      k++;
    end
    chk(done, "R2 frame completes", done, 1);
    chk(j == n, "R2/R4/R10 slot count", j, n);
    chk(load_len == dv, "R6 load width", load_len, dv);
    if (gap_chk) chk(first_rise == dv / 2 - 1, "R8 restart delay", first_rise, dv / 2 - 1);
    for (int b = 0; b < 4; b++) begin
      rd(A_IN0 + b, rv);
      chk(rv == expw[b], "R7 input word", rv, expw[b]);
    end
    if (single) begin
      rd(A_CTRL, rv);
      chk(rv[3] == 1'b0, "R9 start cleared", rv[3], 0);
    end
  endtask

  task automatic idle_check(input int cyc, input string req);
    bit act = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (ser_clk || ser_load) act = 1;
    end
    chk(!act, req, act, 0);
  endtask

  initial begin
    logic [31:0] rv;
    logic [31:0] masks[4];
    masks[0] = 32'hFFFF_FFFF; masks[1] = 32'h8000_0001;
    masks[2] = 32'h0F0F_3C00; masks[3] = 32'h0000_0004;
    rst_n = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; ser_din = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!ser_clk && !ser_dout && !ser_load, "R1 outputs low", {ser_clk, ser_dout, ser_load}, 0);
    rv = '0;
    for (int a = 0; a < 40; a++) begin
      logic [31:0] t;
      rd(a, t);
      rv = rv | t;
    end
    chk(rv == 0, "R1 registers zero", rv, 0);
    idle_check(50, "R1 no frame without request");

    for (int p = 0; p < 32; p++) wr(p, {20'hFFFFF, cfgv(p)});
    rd(5, rv);
    chk(rv == {20'h0, cfgv(5)}, "R3 port word readback", rv, cfgv(5));

    // R2 R3 R4 R5 R7 sweep of bits-per-port, masks and dividers
    for (int nb = 1; nb <= 4; nb++) begin
      for (int mi = 0; mi < 4; mi++) begin
        int dv = 2 + (nb + mi) % 4;
        setup(masks[mi], nb, dv, 0, 1);
        watch_frame(masks[mi], nb, dv, nb * 4 + mi, 0, 0, 1);
      end
    end
    idle_check(100, "R9 no frame after single shot");

    // R10 empty mask
    setup(32'h0, 2, 3, 0, 1);
    watch_frame(32'h0, 2, 3, 1, 0, 0, 1);

    // R5 divider clamp
    setup(32'h0000_0201, 1, 1, 0, 1);
    watch_frame(32'h0000_0201, 1, 2, 2, 0, 0, 1);
    setup(32'h0000_0201, 3, 0, 0, 1);
    watch_frame(32'h0000_0201, 3, 2, 3, 0, 0, 1);

    // R11 mask written mid-frame
    setup(32'hFFFF_FFFF, 2, 3, 0, 1);
    watch_frame(32'hFFFF_FFFF, 2, 3, 5, 0, 1, 1);

    // R8 auto-repeat back to back, then stop
    setup(32'h0000_F00F, 3, 4, 1, 0);
    watch_frame(32'h0000_F00F, 3, 4, 6, 0, 0, 0);
    watch_frame(32'h0000_F00F, 3, 4, 7, 1, 0, 0);
    watch_frame(32'h0000_F00F, 3, 4, 8, 1, 2, 0);
    idle_check(100, "R8 idle after auto off");
    rd(A_CTRL, rv);
    chk(rv[3:0] == 4'd2, "R4/R8 control readback", rv[3:0], 2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule